// File: doc/BRIEF.md
# Dual Receiver Word Latch with Label Filter and Half-Word Readout

This block sits behind a set of serial word assemblers (two by default) and in front of a 16-bit host data bus. When an assembler signals the end of a 32-bit word, the block can check two label bits of the word against two control bits programmed for that receiver. If the check is switched off, or if it is switched on and the bits agree, the word is stored in that receiver's holding register. The receiver's active-low ready output then goes low.

The host reads each stored word in two 16-bit halves. It raises that receiver's read enable and uses a half-select input to pick the half. The data appears on the bus one clock later, together with an output-enable that stands in for a tri-state driver. The ready output returns high only when both halves have been read. If a new qualifying word arrives before then, the old word is replaced without any warning and the record of halves read starts over.

Top module: `arx_dual_readout`

## Requirements
- R1: After synchronous reset every `rdy_n` bit is 1, `bus_oe` is 0 and `bus_data` is 0.
- R2: With `dec_en[i]`=0, an `eos[i]` pulse stores `word_in[i]` and drives `rdy_n[i]` low from the next clock.
- R3: With `dec_en[i]`=1, the word is stored only if word bit 8 (label bit 9) equals `ctl_bits[2i]` and word bit 9 (label bit 10) equals `ctl_bits[2i+1]`. On a mismatch the stored word and `rdy_n[i]` keep their values.
- R4: A cycle with only `rd_en[i]` high is a read. One clock later `bus_oe`=1, and `bus_data` carries stored bits [15:0] (label bits 1–16) when `half_sel`=0, or bits [31:16] (label bits 17–32) when `half_sel`=1.
- R5: `rdy_n[i]` returns to 1 only on the read that completes both halves, taken in either order. Reading the same half again does not clear it.
- R6: A qualifying `eos[i]` while a word is unread replaces the stored word and forgets which halves were already read.
- R7: With more than one `rd_en` bit high, `bus_oe` and `bus_data` are 0 on the next clock and no half is recorded as read.
- R8: With no `rd_en` bit high, `bus_oe` and `bus_data` are 0 on the next clock.
- R9: Each receiver's storage, read record and ready output are independent of the other receivers.
- R10: A qualifying `eos[i]` in the same cycle as a read of receiver i puts the old word's half on the bus. The new word is stored, the read record is cleared and `rdy_n[i]` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eos | input | NRX | End-of-word strobe, one per receiver |
| word_in | input | NRX*32 | Assembled words; receiver i uses bits [32i+31:32i] |
| dec_en | input | NRX | Label filter enable per receiver |
| ctl_bits | input | 2*NRX | Programmed label bits; receiver i uses [2i+1:2i] |
| rd_en | input | NRX | Read enable per receiver |
| half_sel | input | 1 | 0 = low half, 1 = high half |
| rdy_n | output | NRX | Active-low data ready per receiver |
| bus_data | output | 16 | Registered read data |
| bus_oe | output | 1 | Registered bus drive enable |

## Verification
The overlap that matters is a qualifying end-of-word and a host read of the same receiver in one clock. The read may be the one that would complete the pair, so the clear of ready and the set of ready compete. The bench sets this up after one half of a word has been read: it pulses `eos` with a new word and reads the other half in the same cycle. It expects the old half on the bus and `rdy_n` still low. Two more reads of the new word are then needed before ready clears. A second overlap, with both enables raised, is judged by an empty bus and by the record of halves read staying as it was.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int LBL_POS = 8;   // word bit of the first filtered label bit
  localparam int CTL_W   = 2;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/arx_label_gate.sv
module arx_label_gate
  import arx_pkg::*;
(
  input  word_t              word,
  input  logic               dec_en,
  input  logic [CTL_W-1:0]   ctl,
  output logic               pass
);
  logic [CTL_W-1:0] lbl;
  assign lbl  = word[LBL_POS +: CTL_W];
  assign pass = !dec_en || (lbl == ctl);
endmodule

// File: rtl/arx_word_slot.sv
module arx_word_slot
  import arx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  word_t word_in,
  input  logic rd,
  input  logic half_sel,
  output word_t word_q,
  output logic ready
);
  logic [1:0] seen_q;
  logic [1:0] seen_nx;

  always_comb begin
    seen_nx = seen_q;
    seen_nx[half_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      ready  <= 1'b0;
      seen_q <= '0;
    end else if (take) begin
      word_q <= word_in;
      ready  <= 1'b1;
      seen_q <= '0;
    end else if (rd) begin
      if (&seen_nx) begin
        ready  <= 1'b0;
        seen_q <= '0;
      end else begin
        seen_q <= seen_nx;
      end
    end
  end
endmodule

// File: rtl/arx_bus_mux.sv
module arx_bus_mux
  import arx_pkg::*;
#(
  parameter int NRX = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NRX-1:0]        rd_en,
  input  logic                  half_sel,
  input  word_t [NRX-1:0]       words,
  output logic                  legal,
  output half_t                 bus_data,
  output logic                  bus_oe
);
  half_t pick;

  assign legal = (rd_en != '0) && ((rd_en & (rd_en - NRX'(1))) == '0);

  always_comb begin
    pick = '0;
    for (int i = 0; i < NRX; i++) begin
      if (rd_en[i])
        pick = half_sel ? words[i][WORD_W-1:HALF_W] : words[i][HALF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_oe   <= legal;
      bus_data <= legal ? pick : '0;
    end
  end
endmodule

// File: rtl/arx_dual_readout.sv
module arx_dual_readout
  import arx_pkg::*;
#(
  parameter int NRX = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NRX-1:0]          eos,
  input  logic [NRX*WORD_W-1:0]   word_in,
  input  logic [NRX-1:0]          dec_en,
  input  logic [NRX*CTL_W-1:0]    ctl_bits,
  input  logic [NRX-1:0]          rd_en,
  input  logic                    half_sel,
  output logic [NRX-1:0]          rdy_n,
  output logic [HALF_W-1:0]       bus_data,
  output logic                    bus_oe
);
  word_t [NRX-1:0] held;
  logic  [NRX-1:0] ready;
  logic            legal;

  for (genvar g = 0; g < NRX; g++) begin : g_rx
    logic pass;
    arx_label_gate u_gate (
      .word   (word_in[g*WORD_W +: WORD_W]),
      .dec_en (dec_en[g]),
      .ctl    (ctl_bits[g*CTL_W +: CTL_W]),
      .pass   (pass)
    );
    arx_word_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .take     (eos[g] && pass),
      .word_in  (word_in[g*WORD_W +: WORD_W]),
      .rd       (rd_en[g] && legal),
      .half_sel (half_sel),
      .word_q   (held[g]),
      .ready    (ready[g])
    );
  end

  arx_bus_mux #(.NRX(NRX)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .half_sel (half_sel),
    .words    (held),
    .legal    (legal),
    .bus_data (bus_data),
    .bus_oe   (bus_oe)
  );

  assign rdy_n = ~ready;
endmodule

// File: rtl/arx_dual_readout_chk.sv
module arx_dual_readout_chk
  import arx_pkg::*;
#(
  parameter int NRX = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NRX-1:0]          eos,
  input logic [NRX*WORD_W-1:0]   word_in,
  input logic [NRX-1:0]          dec_en,
  input logic [NRX*CTL_W-1:0]    ctl_bits,
  input logic [NRX-1:0]          rd_en,
  input logic                    half_sel,
  input logic [NRX-1:0]          rdy_n,
  input logic [HALF_W-1:0]       bus_data,
  input logic                    bus_oe
);
  a_r7_multi_en_quiet: assert property (@(posedge clk) disable iff (rst)
    ($countones(rd_en) > 1) |=> (!bus_oe && bus_data == '0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (rd_en == '0) |=> (!bus_oe && bus_data == '0));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rdy_n == '1 && !bus_oe));

  for (genvar g = 0; g < NRX; g++) begin : g_chk
    a_r2_open_latch: assert property (@(posedge clk) disable iff (rst)
      (eos[g] && !dec_en[g]) |=> !rdy_n[g]);

    a_r3_mismatch_hold: assert property (@(posedge clk) disable iff (rst)
      (eos[g] && dec_en[g] && rdy_n[g] &&
       word_in[g*WORD_W+LBL_POS +: CTL_W] != ctl_bits[g*CTL_W +: CTL_W])
      |=> rdy_n[g]);

    a_r9_no_read_hold: assert property (@(posedge clk) disable iff (rst)
      (!eos[g] && !rd_en[g]) |=> $stable(rdy_n[g]));
  end
endmodule

bind arx_dual_readout arx_dual_readout_chk #(.NRX(NRX)) u_chk (
  .clk(clk), .rst(rst), .eos(eos), .word_in(word_in), .dec_en(dec_en),
  .ctl_bits(ctl_bits), .rd_en(rd_en), .half_sel(half_sel),
  .rdy_n(rdy_n), .bus_data(bus_data), .bus_oe(bus_oe)
);

// File: tb/sim_arx_dual_readout.sv
`timescale 1ns/1ps
module sim_arx_dual_readout;
  localparam int CLK_NS = 20;
  localparam logic [31:0] WA = 32'hCAFE_0300;  // label bits 10:9 = 11
  localparam logic [31:0] WB = 32'h1357_0112;  // label bits 10:9 = 01
  localparam logic [31:0] WC = 32'h0F0F_0200;  // label bits 10:9 = 10

  typedef struct packed {
    logic [1:0]  eos;
    logic [1:0]  dec;
    logic [3:0]  ctl;
    logic [1:0]  en;
    logic        sel;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [1:0]  x_rdyn;
    logic        x_oe;
    logic [15:0] x_data;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 2'b00, 4'h0, 2'b00, 1'b0, WA, 32'h0, 2'b10, 1'b0, 16'h0000}, // R2 latch rx0
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b0, 32'h0, 32'h0, 2'b10, 1'b1, 16'h0300}, // R4 low half
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b0, 32'h0, 32'h0, 2'b10, 1'b1, 16'h0300}, // R5 repeat half
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b1, 32'h0, 32'h0, 2'b11, 1'b1, 16'hCAFE}, // R4 R5 high half clears
    '{2'b01, 2'b01, 4'h2, 2'b00, 1'b0, WB, 32'h0, 2'b11, 1'b0, 16'h0000}, // R3 mismatch
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b1, 32'h0, 32'h0, 2'b11, 1'b1, 16'hCAFE}, // R3 word kept
    '{2'b01, 2'b01, 4'h1, 2'b00, 1'b0, WB, 32'h0, 2'b10, 1'b0, 16'h0000}, // R3 match
    '{2'b00, 2'b00, 4'h0, 2'b11, 1'b0, 32'h0, 32'h0, 2'b10, 1'b0, 16'h0000}, // R7 both enables
    '{2'b10, 2'b00, 4'h0, 2'b00, 1'b0, 32'h0, WC, 2'b00, 1'b0, 16'h0000}, // R9 rx1 latch
    '{2'b00, 2'b00, 4'h0, 2'b10, 1'b1, 32'h0, 32'h0, 2'b00, 1'b1, 16'h0F0F}, // R9 rx1 read
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b1, 32'h0, 32'h0, 2'b00, 1'b1, 16'h1357}, // R5 one half rx0
    '{2'b01, 2'b00, 4'h0, 2'b01, 1'b0, WA, 32'h0, 2'b00, 1'b1, 16'h0112}, // R10 R6 overlap
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b1, 32'h0, 32'h0, 2'b00, 1'b1, 16'hCAFE}, // R6 record reset
    '{2'b00, 2'b00, 4'h0, 2'b01, 1'b0, 32'h0, 32'h0, 2'b01, 1'b1, 16'h0300}, // R6 now cleared
    '{2'b00, 2'b00, 4'h0, 2'b10, 1'b0, 32'h0, 32'h0, 2'b11, 1'b1, 16'h0200}, // R9 rx1 done
    '{2'b00, 2'b00, 4'h0, 2'b00, 1'b0, 32'h0, 32'h0, 2'b11, 1'b0, 16'h0000}  // R8 idle
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  eos, dec_en, rd_en;
  logic [63:0] word_in;
  logic [3:0]  ctl_bits;
  logic        half_sel;
  logic [1:0]  rdy_n;
  logic [15:0] bus_data;
  logic        bus_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  arx_dual_readout #(.NRX(2)) u0 (
    .clk(clk), .rst(rst), .eos(eos), .word_in(word_in), .dec_en(dec_en),
    .ctl_bits(ctl_bits), .rd_en(rd_en), .half_sel(half_sel),
    .rdy_n(rdy_n), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [1:0] xr,
                       input logic xo, input logic [15:0] xd);
    checks++;
    if (rdy_n !== xr || bus_oe !== xo || bus_data !== xd) begin
      errors++;
      $display("FAIL %s: rdy_n=%b oe=%b data=%h expected rdy_n=%b oe=%b data=%h",
               req, rdy_n, bus_oe, bus_data, xr, xo, xd);
    end
  endtask

  task automatic idle_inputs();
    eos = '0; dec_en = '0; rd_en = '0; word_in = '0; ctl_bits = '0; half_sel = 1'b0;
  endtask

  task automatic step(input logic [1:0] e, input logic [31:0] w0,
                      input logic [1:0] en, input logic sel);
    eos = e; word_in = {32'h0, w0}; rd_en = en; half_sel = sel;
    dec_en = '0; ctl_bits = '0;
    @(negedge clk);
  endtask

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", 2'b11, 1'b0, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      eos = VEC[i].eos; dec_en = VEC[i].dec; ctl_bits = VEC[i].ctl;
      rd_en = VEC[i].en; half_sel = VEC[i].sel;
      word_in = {VEC[i].w1, VEC[i].w0};
      @(negedge clk);
      check($sformatf("vector %0d", i), VEC[i].x_rdyn, VEC[i].x_oe, VEC[i].x_data);
    end

    // R7: double-enable reads record nothing
    step(2'b01, WA, 2'b00, 1'b0);
    check("R2 relatch", 2'b10, 1'b0, 16'h0000);
    step(2'b00, 32'h0, 2'b11, 1'b0);
    step(2'b00, 32'h0, 2'b11, 1'b1);
    check("R7 quiet bus", 2'b10, 1'b0, 16'h0000);
    step(2'b00, 32'h0, 2'b01, 1'b0);
    check("R7 no record", 2'b10, 1'b1, 16'h0300);
    step(2'b00, 32'h0, 2'b01, 1'b1);
    check("R5 pair done", 2'b11, 1'b1, 16'hCAFE);

    // R1: reset while a word is pending
    step(2'b01, WB, 2'b01, 1'b0);
    rst = 1'b1;
    step(2'b00, 32'h0, 2'b00, 1'b0);
    rst = 1'b0;
    check("R1 mid reset", 2'b11, 1'b0, 16'h0000);
    step(2'b00, 32'h0, 2'b01, 1'b1);
    check("R1 word cleared", 2'b11, 1'b1, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule